// File: doc/BRIEF.md
# Cascaded Pacer Clock Generator

This block turns a master time-base strobe into the two pacing streams an acquisition front end needs: one pulse per conversion and one pulse per scan. A prescaler counter in square-wave mode divides the master strobe. Its rising edges then clock two rate-generator counters, one for the conversion rate and one for the scan rate. Both pacing periods are therefore whole multiples of the same prescaled base period. An optional one-shot stop counter counts conversion pulses. Its output rises after a loaded number of conversions, so an externally stopped acquisition ends on a known sample.

The host loads each counter through a single write port that selects the counter by address. It reads sticky terminal-count flags and clears them with a strobe. A small helper divider turns a requested period and a base period into a loadable divisor code. It uses one of three rounding policies and clamps the result to the legal divisor range. The host can use it both for the rate divisors and for choosing the smallest prescaler divisor that still reaches a long scan period.

Top module: `pacer_clock_gen`

## Requirements
- R1: After reset the prescaler output is low, both rate outputs are high, the stop output is low, all status flags are zero, and the divider is neither busy nor done.
- R2: The prescaler (address 0) loaded with divisor N toggles once per master tick count. Its output is high for ceil(N/2) ticks and low for floor(N/2) ticks, so an odd N gives the longer high phase.
- R3: The conversion (address 1) and scan (address 2) counters each give one pulse per N prescaler periods. Each output is low for exactly one prescaler period, and the two counters run independently.
- R4: A loaded divisor code of 0 means 2^W, and a code of 1 is treated as 2 on the prescaler and rate counters.
- R5: Writing a new divisor to a running counter does not disturb the period in progress. The new value takes effect at the counter's next reload.
- R6: Loading the stop counter (address 3) with K drives its output low. The output goes high after K conversion pulses and stays high. K below 3 is raised to 3.
- R7: A stop-arm strobe without a load forces the stop output low, and the stop counter then ignores conversion pulses.
- R8: The status flags are sticky: bit 0 prescaler rise, bit 1 conversion pulse, bit 2 scan pulse, bit 3 stop terminal count. A clear strobe zeroes them.
- R9: The divider returns floor((num + adj)/den). The rounding code sets adj: code 0 and code 3 round to nearest with adj = den/2, code 1 rounds up with adj = den-1, and code 2 rounds down with adj = 0.
- R10: The divider result is clamped to the range 2 to 2^W, and 2^W is returned as code 0.
- R11: Counters advance only on cycles where the master tick is high. With no ticks, every output holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tb_tick | input | 1 | Master time-base strobe, one cycle per base period |
| wr_en | input | 1 | Divisor load strobe |
| wr_addr | input | 2 | Counter select: 0 prescaler, 1 conversion, 2 scan, 3 stop |
| wr_data | input | W | Divisor code (0 means 2^W) |
| stop_arm | input | 1 | Put stop counter in one-shot mode without a count |
| stat_clr | input | 1 | Clear all status flags |
| calc_go | input | 1 | Start a divisor computation |
| calc_num | input | NUMW | Requested period |
| calc_den | input | NUMW | Base period |
| calc_rnd | input | 2 | Rounding policy |
| pre_out | output | 1 | Prescaler square wave |
| conv_out | output | 1 | Conversion rate-generator output |
| scan_out | output | 1 | Scan rate-generator output |
| stop_out | output | 1 | Stop counter output |
| conv_pulse | output | 1 | One-cycle strobe per conversion |
| scan_pulse | output | 1 | One-cycle strobe per scan |
| tc_stat | output | 4 | Sticky terminal-count flags |
| calc_busy | output | 1 | Divider running |
| calc_done | output | 1 | One-cycle strobe, result valid |
| calc_code | output | W | Clamped divisor code |

## Verification
The bench builds the block with W = 8 and NUMW = 24, with the stop counter present. The narrow counter width puts the code-0 meaning of 2^W (256 ticks) within a few hundred cycles. It also brings the divider's upper clamp within reach of small requested periods. The smaller numerator keeps each divide to 25 cycles. The master strobe is driven both every cycle and every third cycle, and it is also held off entirely, so tick gating is observed directly at the outputs.

// File: rtl/pacer_pkg.sv
`timescale 1ns/1ps
package pacer_pkg;

    typedef enum logic [1:0] {
        CNT_SQUARE  = 2'd0,
        CNT_RATE    = 2'd1,
        CNT_ONESHOT = 2'd2
    } cnt_kind_e;

    typedef enum logic [1:0] {
        RND_NEAREST     = 2'd0,
        RND_UP          = 2'd1,
        RND_DOWN        = 2'd2,
        RND_NEAREST_ALT = 2'd3
    } rnd_mode_e;

    typedef enum logic {
        CALC_IDLE = 1'b0,
        CALC_RUN  = 1'b1
    } calc_ph_e;

    localparam logic [1:0] SEL_PRESCALE = 2'd0;
    localparam logic [1:0] SEL_CONVERT  = 2'd1;
    localparam logic [1:0] SEL_SCAN     = 2'd2;
    localparam logic [1:0] SEL_STOP     = 2'd3;

endpackage

// File: rtl/pacer_cnt.sv
`timescale 1ns/1ps
module pacer_cnt
    import pacer_pkg::*;
#(
    parameter int        W    = 16,
    parameter cnt_kind_e KIND = CNT_RATE
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         arm,
    output logic         out,
    output logic         pulse
);

    localparam int             CW         = W + 1;
    localparam logic [CW-1:0]  ONE        = CW'(1);
    localparam logic [CW-1:0]  TWO        = CW'(2);
    localparam logic [CW-1:0]  FULL_DIV   = {1'b1, {W{1'b0}}};
    localparam logic [CW-1:0]  MIN_DIV    = (KIND == CNT_ONESHOT) ? CW'(3) : CW'(2);
    localparam logic           IDLE_LEVEL = (KIND == CNT_RATE);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic [CW-1:0] rld;
        logic          lvl;
        logic          run;
        logic          pls;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] div_dec;
    logic [CW-1:0] phase_hi;
    logic [CW-1:0] phase_lo;
    logic [CW-1:0] start_hi;

    // decode the loaded code: 0 means full range, small values raised to the floor
    always_comb begin
        div_dec = (load_val == '0) ? FULL_DIV : {1'b0, load_val};
        if (div_dec < MIN_DIV) begin
            div_dec = MIN_DIV;
        end
        phase_hi = (st_q.rld >> 1) + CW'(st_q.rld[0]);
        phase_lo = st_q.rld >> 1;
        start_hi = (div_dec >> 1) + CW'(div_dec[0]);
    end

    always_comb begin
        st_d     = st_q;
        st_d.pls = 1'b0;
        case (KIND)
            CNT_SQUARE: begin
                if (en && st_q.run) begin
                    if (st_q.cnt == ONE) begin
                        st_d.lvl = ~st_q.lvl;
                        st_d.cnt = st_q.lvl ? phase_lo : phase_hi;
                        st_d.pls = ~st_q.lvl;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                if (load) begin
                    st_d.rld = div_dec;
                    if (!st_q.run) begin
                        st_d.run = 1'b1;
                        st_d.lvl = 1'b1;
                        st_d.pls = 1'b1;
                        st_d.cnt = start_hi;
                    end
                end
            end
            CNT_RATE: begin
                if (en && st_q.run) begin
                    if (st_q.cnt == TWO) begin
                        st_d.cnt = ONE;
                        st_d.lvl = 1'b0;
                        st_d.pls = 1'b1;
                    end else if (st_q.cnt == ONE) begin
                        st_d.cnt = st_q.rld;
                        st_d.lvl = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                if (load) begin
                    st_d.rld = div_dec;
                    if (!st_q.run) begin
                        st_d.run = 1'b1;
                        st_d.lvl = 1'b1;
                        st_d.cnt = div_dec;
                    end
                end
            end
            default: begin
                if (en && st_q.run) begin
                    if (st_q.cnt == ONE) begin
                        st_d.cnt = '0;
                        st_d.lvl = 1'b1;
                        st_d.run = 1'b0;
                        st_d.pls = 1'b1;
                    end else begin
                        st_d.cnt = st_q.cnt - ONE;
                    end
                end
                if (load) begin
                    st_d.cnt = div_dec;
                    st_d.rld = div_dec;
                    st_d.lvl = 1'b0;
                    st_d.run = 1'b1;
                end
            end
        endcase
        if (arm && !load) begin
            st_d.run = 1'b0;
            st_d.lvl = IDLE_LEVEL;
            st_d.pls = 1'b0;
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, rld: MIN_DIV, lvl: IDLE_LEVEL, run: 1'b0, pls: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign out   = st_q.lvl;
    assign pulse = st_q.pls;

    // R11
    cnt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!en && !load && !arm) |=> $stable(st_q.cnt));

    generate
        if (KIND == CNT_RATE) begin : g_rate_chk
            // R3
            rate_low_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.run && !st_q.lvl && en) |=> st_q.lvl);
        end else if (KIND == CNT_SQUARE) begin : g_sq_chk
            // R2
            sq_pulse_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
                st_q.pls |-> st_q.lvl);
        end else begin : g_stop_chk
            // R6
            stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.lvl && !load && !arm) |=> st_q.lvl);
            // R7
            stop_arm_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (arm && !load) |=> !st_q.lvl);
        end
    endgenerate

endmodule

// File: rtl/pacer_div_calc.sv
`timescale 1ns/1ps
module pacer_div_calc
    import pacer_pkg::*;
#(
    parameter int W    = 16,
    parameter int NUMW = 32
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NUMW-1:0] num,
    input  logic [NUMW-1:0] den,
    input  logic [1:0]      rnd,
    output logic            busy,
    output logic            done,
    output logic [W-1:0]    code
);

    localparam int              CW   = NUMW + 1;
    localparam int              IW   = $clog2(CW + 1);
    localparam logic [CW-1:0]   FULL = CW'(1) << W;
    localparam logic [NUMW-1:0] NONE = NUMW'(1);

    typedef struct packed {
        calc_ph_e        ph;
        logic [CW-1:0]   quo;
        logic [NUMW-1:0] rem;
        logic [NUMW-1:0] dv;
        logic [IW-1:0]   iter;
        logic            fin;
        logic [W-1:0]    res;
    } calc_st_t;

    calc_st_t        st_d, st_q;
    logic [NUMW-1:0] adj;
    logic [CW-1:0]   num_sum;
    logic [CW-1:0]   shifted;
    logic [CW-1:0]   quo_sh;
    logic            ge;

    function automatic logic [W-1:0] clamp_code(input logic [CW-1:0] q);
        if (q < CW'(2)) begin
            return W'(2);
        end else if (q >= FULL) begin
            return '0;
        end else begin
            return q[W-1:0];
        end
    endfunction

    always_comb begin
        case (rnd_mode_e'(rnd))
            RND_UP:   adj = (den == '0) ? '0 : den - NONE;
            RND_DOWN: adj = '0;
            default:  adj = den >> 1;
        endcase
        num_sum = {1'b0, num} + {1'b0, adj};
        shifted = {st_q.rem, st_q.quo[CW-1]};
        ge      = shifted >= {1'b0, st_q.dv};
        quo_sh  = {st_q.quo[CW-2:0], ge};
    end

    always_comb begin
        st_d     = st_q;
        st_d.fin = 1'b0;
        case (st_q.ph)
            CALC_IDLE: begin
                if (go) begin
                    st_d.ph   = CALC_RUN;
                    st_d.quo  = num_sum;
                    st_d.rem  = '0;
                    st_d.dv   = den;
                    st_d.iter = IW'(CW);
                end
            end
            default: begin
                st_d.quo  = quo_sh;
                st_d.rem  = ge ? (shifted[NUMW-1:0] - st_q.dv) : shifted[NUMW-1:0];
                st_d.iter = st_q.iter - IW'(1);
                if (st_q.iter == IW'(1)) begin
                    st_d.ph  = CALC_IDLE;
                    st_d.fin = 1'b1;
                    st_d.res = clamp_code(quo_sh);
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{ph: CALC_IDLE, quo: '0, rem: '0, dv: '0, iter: '0, fin: 1'b0, res: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy = (st_q.ph == CALC_RUN);
    assign done = st_q.fin;
    assign code = st_q.res;

    // R9
    calc_phase_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({busy, done}));
    // R10
    calc_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (code != W'(1)));

endmodule

// File: rtl/pacer_clock_gen.sv
`timescale 1ns/1ps
module pacer_clock_gen
    import pacer_pkg::*;
#(
    parameter int W        = 16,
    parameter int NUMW     = 32,
    parameter bit HAS_STOP = 1'b1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tb_tick,
    input  logic            wr_en,
    input  logic [1:0]      wr_addr,
    input  logic [W-1:0]    wr_data,
    input  logic            stop_arm,
    input  logic            stat_clr,
    input  logic            calc_go,
    input  logic [NUMW-1:0] calc_num,
    input  logic [NUMW-1:0] calc_den,
    input  logic [1:0]      calc_rnd,
    output logic            pre_out,
    output logic            conv_out,
    output logic            scan_out,
    output logic            stop_out,
    output logic            conv_pulse,
    output logic            scan_pulse,
    output logic [3:0]      tc_stat,
    output logic            calc_busy,
    output logic            calc_done,
    output logic [W-1:0]    calc_code
);

    localparam int NFLAG = 4;

    typedef struct packed {
        logic [NFLAG-1:0] flags;
    } top_st_t;

    top_st_t          st_d, st_q;
    logic             pre_pulse;
    logic             stop_pulse;
    logic [NFLAG-1:0] evt;

    pacer_cnt #(.W(W), .KIND(CNT_SQUARE)) u_pre (
        .clk(clk), .rst_n(rst_n), .en(tb_tick),
        .load(wr_en && (wr_addr == SEL_PRESCALE)), .load_val(wr_data), .arm(1'b0),
        .out(pre_out), .pulse(pre_pulse)
    );

    pacer_cnt #(.W(W), .KIND(CNT_RATE)) u_conv (
        .clk(clk), .rst_n(rst_n), .en(pre_pulse),
        .load(wr_en && (wr_addr == SEL_CONVERT)), .load_val(wr_data), .arm(1'b0),
        .out(conv_out), .pulse(conv_pulse)
    );

    pacer_cnt #(.W(W), .KIND(CNT_RATE)) u_scan (
        .clk(clk), .rst_n(rst_n), .en(pre_pulse),
        .load(wr_en && (wr_addr == SEL_SCAN)), .load_val(wr_data), .arm(1'b0),
        .out(scan_out), .pulse(scan_pulse)
    );

    generate
        if (HAS_STOP) begin : g_stop
            pacer_cnt #(.W(W), .KIND(CNT_ONESHOT)) u_stop (
                .clk(clk), .rst_n(rst_n), .en(conv_pulse),
                .load(wr_en && (wr_addr == SEL_STOP)), .load_val(wr_data), .arm(stop_arm),
                .out(stop_out), .pulse(stop_pulse)
            );
        end else begin : g_no_stop
            assign stop_out   = 1'b0;
            assign stop_pulse = 1'b0;
        end
    endgenerate

    pacer_div_calc #(.W(W), .NUMW(NUMW)) u_calc (
        .clk(clk), .rst_n(rst_n), .go(calc_go),
        .num(calc_num), .den(calc_den), .rnd(calc_rnd),
        .busy(calc_busy), .done(calc_done), .code(calc_code)
    );

    always_comb begin
        evt          = {stop_pulse, scan_pulse, conv_pulse, pre_pulse};
        st_d.flags   = (stat_clr ? '0 : st_q.flags) | evt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{flags: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign tc_stat = st_q.flags;

    generate
        for (genvar i = 0; i < NFLAG; i++) begin : g_flag_chk
            // R8
            stat_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (st_q.flags[i] && !stat_clr) |=> st_q.flags[i]);
        end
    endgenerate

endmodule

// File: tb/pacer_clock_gen_tb.sv
`timescale 1ns/1ps
module pacer_clock_gen_tb_top;

    localparam int W    = 8;
    localparam int NUMW = 24;

    logic            clk = 1'b0;
    logic            rst_n;
    logic            tb_tick;
    logic            wr_en;
    logic [1:0]      wr_addr;
    logic [W-1:0]    wr_data;
    logic            stop_arm;
    logic            stat_clr;
    logic            calc_go;
    logic [NUMW-1:0] calc_num;
    logic [NUMW-1:0] calc_den;
    logic [1:0]      calc_rnd;
    logic            pre_out, conv_out, scan_out, stop_out;
    logic            conv_pulse, scan_pulse;
    logic [3:0]      tc_stat;
    logic            calc_busy, calc_done;
    logic [W-1:0]    calc_code;

    int n_chk  = 0;
    int n_bad  = 0;
    int tick_div = 1;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    pacer_clock_gen #(.W(W), .NUMW(NUMW), .HAS_STOP(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .tb_tick(tb_tick),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .stop_arm(stop_arm), .stat_clr(stat_clr),
        .calc_go(calc_go), .calc_num(calc_num), .calc_den(calc_den), .calc_rnd(calc_rnd),
        .pre_out(pre_out), .conv_out(conv_out), .scan_out(scan_out), .stop_out(stop_out),
        .conv_pulse(conv_pulse), .scan_pulse(scan_pulse), .tc_stat(tc_stat),
        .calc_busy(calc_busy), .calc_done(calc_done), .calc_code(calc_code)
    );

    initial begin
        int ph;
        ph = 0;
        tb_tick = 1'b0;
        forever begin
            @(negedge clk);
            if (tick_div == 0) begin
                tb_tick = 1'b0;
            end else begin
                ph++;
                if (ph >= tick_div) begin
                    ph = 0;
                    tb_tick = 1'b1;
                end else begin
                    tb_tick = 1'b0;
                end
            end
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
        stop_arm = 1'b0; stat_clr = 1'b0; calc_go = 1'b0;
        calc_num = '0; calc_den = '0; calc_rnd = '0; tick_div = 1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d);
        wr_addr = a; wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic sq_lengths(output int hi, output int lo);
        @(negedge clk);
        while (pre_out) @(negedge clk);
        while (!pre_out) @(negedge clk);
        hi = 0;
        while (pre_out) begin hi++; @(negedge clk); end
        lo = 0;
        while (!pre_out) begin lo++; @(negedge clk); end
    endtask

    task automatic conv_gap(output int g);
        @(negedge clk);
        while (!conv_pulse) @(negedge clk);
        g = 0;
        do begin @(negedge clk); g++; end while (!conv_pulse);
    endtask

    task automatic scan_gap(output int g);
        @(negedge clk);
        while (!scan_pulse) @(negedge clk);
        g = 0;
        do begin @(negedge clk); g++; end while (!scan_pulse);
    endtask

    task automatic conv_low_len(output int n);
        @(negedge clk);
        while (!conv_out) @(negedge clk);
        while (conv_out) @(negedge clk);
        n = 0;
        while (!conv_out) begin n++; @(negedge clk); end
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pre_out", pre_out, 0);
        chk("R1 conv_out", conv_out, 1);
        chk("R1 scan_out", scan_out, 1);
        chk("R1 stop_out", stop_out, 0);
        chk("R1 tc_stat", tc_stat, 0);
        chk("R1 calc_busy", calc_busy, 0);
        chk("R1 calc_done", calc_done, 0);
    endtask

    task automatic t_square();
        int hi, lo;
        do_reset();
        wr(2'd0, 8'd4);
        sq_lengths(hi, lo);
        chk("R2 even high", hi, 2);
        chk("R2 even low", lo, 2);
        do_reset();
        wr(2'd0, 8'd5);
        sq_lengths(hi, lo);
        chk("R2 odd high", hi, 3);
        chk("R2 odd low", lo, 2);
    endtask

    task automatic t_rate();
        int g, n;
        do_reset();
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd3);
        wr(2'd2, 8'd5);
        conv_gap(g);
        conv_gap(g);
        chk("R3 conv period", g, 12);
        scan_gap(g);
        scan_gap(g);
        chk("R3 scan period", g, 20);
        conv_low_len(n);
        chk("R3 conv low one base period", n, 4);
    endtask

    task automatic t_clamp();
        int g, hi, lo;
        do_reset();
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd1);
        conv_gap(g);
        conv_gap(g);
        chk("R4 code 1 acts as 2", g, 4);
        do_reset();
        wr(2'd0, 8'd0);
        sq_lengths(hi, lo);
        chk("R4 code 0 high", hi, 128);
        chk("R4 code 0 low", lo, 128);
    endtask

    task automatic t_reload();
        int g;
        do_reset();
        wr(2'd0, 8'd4);
        wr(2'd1, 8'd3);
        conv_gap(g);
        @(negedge clk);
        while (!conv_pulse) @(negedge clk);
        repeat (5) @(negedge clk);
        wr(2'd1, 8'd6);
        g = 6;
        do begin @(negedge clk); g++; end while (!conv_pulse);
        chk("R5 period in progress keeps old divisor", g, 12);
        g = 0;
        do begin @(negedge clk); g++; end while (!conv_pulse);
        chk("R5 next period uses new divisor", g, 24);
    endtask

    task automatic t_stop();
        int cnt, held;
        do_reset();
        wr(2'd0, 8'd2);
        wr(2'd1, 8'd2);
        repeat (10) @(negedge clk);
        wr(2'd3, 8'd5);
        chk("R6 stop low after load", stop_out, 0);
        cnt = 0;
        while (!stop_out && cnt < 100) begin
            if (conv_pulse) cnt++;
            @(negedge clk);
        end
        chk("R6 stop after K conversions", cnt, 5);
        held = 1;
        repeat (20) begin @(negedge clk); if (!stop_out) held = 0; end
        chk("R6 stop output holds high", held, 1);
        chk("R8 stop flag set", tc_stat[3], 1);
        stat_clr = 1'b1;
        @(negedge clk);
        stat_clr = 1'b0;
        @(negedge clk);
        chk("R8 stop flag cleared", tc_stat[3], 0);
        stop_arm = 1'b1;
        @(negedge clk);
        stop_arm = 1'b0;
        held = 1;
        repeat (30) begin if (stop_out) held = 0; @(negedge clk); end
        chk("R7 arm forces and keeps low", held, 1);
        wr(2'd3, 8'd1);
        cnt = 0;
        while (!stop_out && cnt < 100) begin
            if (conv_pulse) cnt++;
            @(negedge clk);
        end
        chk("R6 small count raised to 3", cnt, 3);
    endtask

    task automatic t_tick();
        int hi, lo, same;
        logic p0;
        do_reset();
        tick_div = 3;
        wr(2'd0, 8'd2);
        sq_lengths(hi, lo);
        chk("R11 high spans one tick", hi, 3);
        chk("R11 low spans one tick", lo, 3);
        tick_div = 0;
        repeat (2) @(negedge clk);
        p0 = pre_out;
        same = 1;
        repeat (30) begin @(negedge clk); if (pre_out != p0) same = 0; end
        chk("R11 no tick holds output", same, 1);
    endtask

    task automatic run_calc(input int num, input int den, input int rnd, input int exp, input string tag);
        int n;
        calc_num = NUMW'(num); calc_den = NUMW'(den); calc_rnd = 2'(rnd);
        calc_go = 1'b1;
        @(negedge clk);
        calc_go = 1'b0;
        n = 0;
        while (!calc_done && n < 100) begin @(negedge clk); n++; end
        chk(tag, calc_code, exp);
    endtask

    task automatic t_calc();
        do_reset();
        run_calc(1250, 500, 0, 3, "R9 nearest half rounds up");
        run_calc(1250, 500, 1, 3, "R9 round up");
        run_calc(1250, 500, 2, 2, "R9 round down");
        run_calc(1100, 500, 0, 2, "R9 nearest below half");
        run_calc(1100, 500, 1, 3, "R9 up fraction");
        run_calc(1249, 500, 3, 2, "R9 alt code nearest");
        run_calc(300000, 128000, 1, 3, "R9 prescaler pick");
        run_calc(700, 500, 2, 2, "R10 floor clamp");
        run_calc(127500, 500, 2, 255, "R10 top in range");
        run_calc(128000, 500, 2, 0, "R10 full range code");
        run_calc(200000, 500, 0, 0, "R10 ceiling clamp");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_square();
        t_rate();
        t_clamp();
        t_reload();
        t_stop();
        t_tick();
        t_calc();
        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule